// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block holds one address reservation for atomic read-modify-write sequences built from a reserving load and a conditional store. A reserving load records the cache-line address of its access and marks the reservation valid. A later conditional store compares its own line address with the reservation. On a match it goes on to the normal store path and is reported as successful. On a miss its memory write is suppressed and it is reported as failed. An atomic access can be split into several parts, and only the part flagged as the last one changes the reservation.

The block sits in a two-stage load/store pipeline and accepts one request per clock. A request presented in cycle N is registered and evaluated in cycle N+1. In that cycle the block drives the cancel and write-issue decisions and updates the reservation at the closing edge. The completion status appears in cycle N+2. The reservation is compared on whole cache lines, so the offset bits inside a line are ignored. Loss of the reservation caused by traffic from other bus masters is not handled here.

Top module: `lsc_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the reservation becomes invalid. `st_cancel`, `st_issue`, `done_valid`, `done_cond` and `done_ok` are all 0 in the cycle after that edge.
- R2: A reserving load (`req_kind` = 2) with `req_last` = 1, presented in cycle N, makes `resv_valid` = 1 and `resv_line` = `req_addr[ADDR_W-1:LINE_OFF]` from cycle N+2 on.
- R3: A reserving load with `req_last` = 0 leaves `resv_valid` and `resv_line` unchanged.
- R4: A conditional store (`req_kind` = 3) presented in cycle N drives `st_cancel` = 1 and `st_issue` = 0 in cycle N+1 when the reservation is invalid or its line differs from the store's line. This holds whatever the value of `req_last`.
- R5: Addresses that differ only in the low LINE_OFF bits (LINE_OFF = log2 of LINE_BYTES, 6 by default) count as the same line for the reservation compare.
- R6: A conditional store with `req_last` = 1 leaves the reservation invalid from cycle N+2, whether it succeeded or failed. With `req_last` = 0, the reservation is unchanged.
- R7: Plain loads (`req_kind` = 0) and plain stores (`req_kind` = 1) never change the reservation. A plain store drives `st_issue` = 1 and `st_cancel` = 0 in cycle N+1. A plain load drives both to 0.
- R8: Every request presented with `req_valid` = 1 in cycle N gives `done_valid` = 1 in cycle N+2. `done_cond` = 1 marks a conditional store, and `done_ok` = 1 marks a conditional store that was not cancelled. `done_valid` is 0 in every other cycle, and `done_cond` and `done_ok` are 0 whenever `done_valid` is 0.
- R9: A conditional store whose line matches a valid reservation drives `st_issue` = 1 and `st_cancel` = 0 in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 plain load, 1 plain store, 2 reserving load, 3 conditional store |
| req_last | input | 1 | Request is the last part of its atomic access |
| req_addr | input | ADDR_W | Byte address of the request |
| resv_valid | output | 1 | Reservation held |
| resv_line | output | ADDR_W-LINE_OFF | Reserved line address |
| st_cancel | output | 1 | Store in stage 1 is a conditional store that must not write |
| st_issue | output | 1 | Store in stage 1 goes on to the memory write path |
| done_valid | output | 1 | Completion of the request in stage 2 |
| done_cond | output | 1 | Completed request was a conditional store |
| done_ok | output | 1 | Conditional store succeeded |

## Verification
The bench targets these corner cases:
- **Back-to-back reserve then store.** A conditional store issued right behind a reserving load to the same line must succeed. A design that forwarded the reservation a cycle late would cancel it.
- **Offset-only address differences.** A store that differs from the reservation only in its offset bits must match. A design that compared full addresses would fail that store spuriously.
- **Non-last parts.** Reserving loads and conditional stores with the last flag clear must leave the reservation alone. A design that ignored the flag would set or drop the reservation early.
- **Failed last-part stores.** A conditional store that fails with the last flag set must still clear the reservation. A design that cleared only on success would let a later store succeed wrongly.
- **Random mix against a model.** A long random mix over a few nearby lines is compared against a behavioural model on every cycle.

// File: rtl/lsc_pkg.sv
// Shared request encoding for the reservation tracker.
// Assumes a 2-bit request kind field driven by the load/store unit.
package lsc_pkg;
    typedef enum logic [1:0] {
        KIND_LOAD       = 2'd0,
        KIND_STORE      = 2'd1,
        KIND_RSV_LOAD   = 2'd2,
        KIND_COND_STORE = 2'd3
    } lsc_kind_e;
endpackage

// File: rtl/lsc_stage.sv
// Stage-1 request register: captures one request per cycle.
// Assumes the pipeline never stalls; a new request may arrive every clock.
module lsc_stage
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  lsc_kind_e         in_kind,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              s1_valid,
    output lsc_kind_e         s1_kind,
    output logic              s1_last,
    output logic [ADDR_W-1:0] s1_addr
);
    // Capture the incoming request; only the valid bit needs a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
        s1_kind <= in_kind;
        s1_last <= in_last;
        s1_addr <= in_addr;
    end
endmodule

// File: rtl/lsc_resv.sv
// Reservation register with line-address compare.
// Assumes set and clear are never requested in the same cycle.
module lsc_resv #(
    parameter int TAG_W = 58
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] cmp_line,
    output logic             held,
    output logic [TAG_W-1:0] held_line,
    output logic             hit
);
    // Record or drop the reservation at the end of stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (set_en) begin
            held      <= 1'b1;
            held_line <= cmp_line;
        end else if (clr_en) begin
            held <= 1'b0;
        end
    end

    // Match needs a live reservation on the same line.
    always_comb begin
        hit = held && (held_line == cmp_line);
    end
endmodule

// File: rtl/lsc_done.sv
// Stage-2 completion register carrying conditional-store status.
// Assumes the cancel decision is stable during stage 1.
module lsc_done (
    input  logic clk,
    input  logic rst_n,
    input  logic s1_valid,
    input  logic s1_cond,
    input  logic s1_cancel,
    output logic done_valid,
    output logic done_cond,
    output logic done_ok
);
    // Register completion one cycle after evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_cond  <= 1'b0;
            done_ok    <= 1'b0;
        end else begin
            done_valid <= s1_valid;
            done_cond  <= s1_valid && s1_cond;
            done_ok    <= s1_valid && s1_cond && !s1_cancel;
        end
    end
endmodule

// File: rtl/lsc_tracker.sv
// Load-reserve / store-conditional tracker, top level.
// Stage 1 evaluates a request against the reservation; stage 2 reports completion.
// Assumes one request per cycle and no external reservation loss.
module lsc_tracker
    import lsc_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 64,
    localparam int LINE_OFF  = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - LINE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resv_valid,
    output logic [TAG_W-1:0]  resv_line,
    output logic              st_cancel,
    output logic              st_issue,
    output logic              done_valid,
    output logic              done_cond,
    output logic              done_ok
);
    logic              s1_valid;
    lsc_kind_e         s1_kind;
    logic              s1_last;
    logic [ADDR_W-1:0] s1_addr;
    logic              is_cond;
    logic              is_rsv;
    logic              line_hit;
    logic              set_en;
    logic              clr_en;

    lsc_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_kind  (lsc_kind_e'(req_kind)),
        .in_last  (req_last),
        .in_addr  (req_addr),
        .s1_valid (s1_valid),
        .s1_kind  (s1_kind),
        .s1_last  (s1_last),
        .s1_addr  (s1_addr)
    );

    // Decode the stage-1 request and form the store-path decisions.
    always_comb begin
        is_cond   = s1_valid && (s1_kind == KIND_COND_STORE);
        is_rsv    = s1_valid && (s1_kind == KIND_RSV_LOAD);
        set_en    = is_rsv && s1_last;
        clr_en    = is_cond && s1_last;
        st_cancel = is_cond && !line_hit;
        st_issue  = (s1_valid && (s1_kind == KIND_STORE)) || (is_cond && line_hit);
    end

    lsc_resv #(.TAG_W(TAG_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .clr_en    (clr_en),
        .cmp_line  (s1_addr[ADDR_W-1:LINE_OFF]),
        .held      (resv_valid),
        .held_line (resv_line),
        .hit       (line_hit)
    );

    lsc_done u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_cond    (is_cond),
        .s1_cancel  (st_cancel),
        .done_valid (done_valid),
        .done_cond  (done_cond),
        .done_ok    (done_ok)
    );
endmodule

// File: rtl/lsc_tracker_chk.sv
// Property checker for the reservation tracker, bound to the top.
module lsc_tracker_chk #(
    parameter int ADDR_W = 64,
    parameter int TAG_W  = 58
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_last,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resv_valid,
    input logic [TAG_W-1:0]  resv_line,
    input logic              st_cancel,
    input logic              st_issue,
    input logic              done_valid,
    input logic              done_cond,
    input logic              done_ok
);
    assert_cancel_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_cancel |-> ($past(req_valid) && $past(req_kind) == 2'd3));

    assert_no_write_on_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_cancel && st_issue));

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(req_valid, 2));

    assert_ok_needs_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> (done_cond && $past(st_issue)));

    assert_set_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && $past(req_kind, 2) == 2'd2 && $past(req_last, 2))
        |-> (resv_valid && resv_line == $past(req_addr[ADDR_W-1:ADDR_W-TAG_W], 2)));

    assert_clear_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_cond && $past(req_last, 2)) |-> !resv_valid);

    assert_resv_only_by_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_valid != $past(resv_valid)) |-> $past(req_valid, 2));
endmodule

bind lsc_tracker lsc_tracker_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/lsc_tracker_bench.sv
// Bench: behavioural reference model compared every cycle.
module lsc_tracker_bench;
    localparam int AW = 64;
    localparam int OFF = 6;
    localparam int TW = AW - OFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_last = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          resv_valid, st_cancel, st_issue, done_valid, done_cond, done_ok;
    logic [TW-1:0] resv_line;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    bit          m_rv = 0;
    bit [TW-1:0] m_rl = '0;
    bit          s_v = 0, s_last = 0;
    bit [1:0]    s_k = 0;
    bit [AW-1:0] s_a = '0;
    bit          d_v = 0, d_c = 0, d_ok = 0;

    lsc_tracker u_lsc_tracker (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, string nm, logic [63:0] act, logic [63:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    function automatic bit m_cancel();
        return s_v && s_k == 2'd3 && !(m_rv && m_rl == s_a[AW-1:OFF]);
    endfunction

    // Model one clock edge using pre-edge state and the inputs just driven.
    task automatic model_edge();
        bit c;
        c = m_cancel();
        if (!rst_n) begin
            m_rv = 0; d_v = 0; d_c = 0; d_ok = 0; s_v = 0;
        end else begin
            d_v = s_v;
            d_c = s_v && s_k == 2'd3;
            d_ok = d_c && !c;
            if (s_v && s_k == 2'd2 && s_last) begin m_rv = 1; m_rl = s_a[AW-1:OFF]; end
            else if (s_v && s_k == 2'd3 && s_last) m_rv = 0;
            s_v = req_valid;
        end
        s_k = req_kind; s_last = req_last; s_a = req_addr;
    endtask

    task automatic compare();
        vectors++;
        chk("R2 R3 R6 R7", "resv_valid", resv_valid, m_rv);
        if (m_rv) chk("R2 R5", "resv_line", resv_line, m_rl);
        chk("R4", "st_cancel", st_cancel, m_cancel());
        chk("R7 R9", "st_issue", st_issue,
            s_v && (s_k == 2'd1 || (s_k == 2'd3 && !m_cancel())));
        chk("R8", "done_valid", done_valid, d_v);
        chk("R8", "done_cond", done_cond, d_c);
        chk("R8", "done_ok", done_ok, d_ok);
    endtask

    task automatic step(bit v, bit [1:0] k, bit l, bit [AW-1:0] a);
        req_valid = v; req_kind = k; req_last = l; req_addr = a;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    localparam bit [AW-1:0] LA = 64'h0000_1234_5678_9A40;
    localparam bit [AW-1:0] LB = LA + 64'h40;

    initial begin
        // R1: reset state
        req_valid = 1'b1; req_kind = 2'd3; req_last = 1'b1;
        step(1, 2'd3, 1, LA);
        step(0, 2'd0, 0, 0);
        rst_n = 1'b1;
        chk("R1", "resv_valid", resv_valid, 0);
        chk("R1", "done_valid", done_valid, 0);
        chk("R1", "st_cancel", st_cancel, 0);
        vectors++;
        // R4: conditional store with no reservation
        step(1, 2'd3, 1, LA);
        chk("R4", "st_cancel_noresv", st_cancel, 1);
        step(0, 2'd0, 0, 0);
        chk("R8", "done_ok_fail", done_ok, 0);
        // R3: non-last reserving load does nothing
        step(1, 2'd2, 0, LA);
        step(0, 2'd0, 0, 0);
        step(0, 2'd0, 0, 0);
        chk("R3", "resv_after_nonlast", resv_valid, 0);
        // R2: reserving load, last part
        step(1, 2'd2, 1, LA);
        step(0, 2'd0, 0, 0);
        chk("R2", "resv_set", resv_valid, 1);
        chk("R2", "resv_line", resv_line, LA[AW-1:OFF]);
        // R7: plain traffic leaves reservation alone
        step(1, 2'd1, 1, LB);
        chk("R7", "plain_store_issue", st_issue, 1);
        step(1, 2'd0, 1, LB);
        step(0, 2'd0, 0, 0);
        chk("R7", "resv_kept", resv_valid, 1);
        // R5 R9 R6: same line, other offset, non-last: success, kept
        step(1, 2'd3, 0, LA + 64'h3F);
        chk("R9", "st_issue_hit", st_issue, 1);
        chk("R5", "st_cancel_offset", st_cancel, 0);
        step(0, 2'd0, 0, 0);
        chk("R8", "done_ok_hit", done_ok, 1);
        chk("R6", "resv_kept_nonlast", resv_valid, 1);
        // R4 R6: mismatched line, last part: cancel and clear
        step(1, 2'd3, 1, LB);
        chk("R4", "st_cancel_mismatch", st_cancel, 1);
        step(0, 2'd0, 0, 0);
        chk("R6", "resv_cleared_fail", resv_valid, 0);
        // R2 R9 back-to-back, then R6 second store fails
        step(1, 2'd2, 1, LB);
        step(1, 2'd3, 1, LB + 64'h8);
        chk("R9", "b2b_issue", st_issue, 1);
        step(1, 2'd3, 1, LB);
        chk("R6", "second_cancel", st_cancel, 1);
        step(0, 2'd0, 0, 0);
        // random mix over three lines
        for (int i = 0; i < 2000; i++) begin
            bit [AW-1:0] a;
            a = LA + 64'($urandom_range(0, 2)) * 64'h40 + 64'($urandom_range(0, 63));
            step(1'($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom_range(0, 3) != 0), a);
        end
        for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule